// File: doc/BRIEF.md
# Reference Clock Loss Watchdog

This block runs on a free-running system clock and watches a slower reference clock. It brings the reference into the system-clock domain through a synchronizer, finds its rising edges and measures each reference period in system-clock cycles. From these measurements it keeps a lock state and publishes it as an unlock flag and a gate enable for a synthesized output clock.

A reference loss is handled in one of two ways. A reference that simply stops is tolerated for a long, fixed count of system cycles before unlock is raised, and the clock-skip setting does not change this. An edge that arrives early, which marks a glitch or a faster clock, counts as a frequency change and unlocks at once. A late edge is treated the same way unless clock-skip is enabled and the gap was long enough to count as a deliberate interruption. While unlocked, a configuration bit chooses whether the output is held low or keeps running with an invalid flag. Once a steady reference is seen again, lock returns only after a programmable lock time.

Top module: `refclk_watchdog`

## Requirements
- R1: Once the reference stops with no glitch, unlock stays low for 2^TO_EXP system cycles after the last detected rising edge and is high after that time. This holds for both values of cfg_skip_en.
- R2: While locked, an edge that ends a period more than TOL cycles shorter than the latched period raises unlock on the next clock. This holds for both values of cfg_skip_en.
- R3: While locked, out_en is 1 and out_invalid is 0. While unlocked, out_en and out_invalid both equal cfg_keep_run: 0 holds the output low, and 1 lets it run with the invalid flag set.
- R4: After an unlock, the block stays unlocked for at least LOCK_CYC cycles of steady reference before it clears unlock and out_invalid.
- R5: When cfg_skip_en is 1 and the block is locked, a gap between edges that is at least SKIP_MIN cycles and shorter than the timeout does not raise unlock. The period latched before the gap stays in force for the edges that follow.
- R6: When cfg_skip_en is 0, the same gap raises unlock when the reference returns.
- R7: While locked, a measured period that differs from the latched one by more than TOL cycles, and that is not a gap accepted under R5, raises unlock. A difference of TOL or less keeps lock.
- R8: If the reference stays quiet for longer than the latched period plus TOL while lock is being acquired, the lock-time count restarts from zero.
- R9: After reset the block is unlocked. It asserts lock no earlier than LOCK_CYC cycles after two reference edges have been measured.
- R10: out_en and out_invalid follow cfg_keep_run in the same cycle. A change of cfg_keep_run or cfg_skip_en does not restart the lock-time count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_clk | input | 1 | Reference clock, asynchronous to clk |
| cfg_keep_run | input | 1 | 1: output runs while unlocked and is flagged invalid; 0: output is held low |
| cfg_skip_en | input | 1 | 1: a long interruption shorter than the timeout is tolerated |
| unlock | output | 1 | 1 while the block is not locked |
| out_en | output | 1 | Gate enable for the synthesized output clock |
| out_invalid | output | 1 | 1 while the output runs during unlock |

## Verification
A reference rising edge is seen on the third system edge after it is driven, and unlock responds one clock after that. out_en and out_invalid follow the state and cfg_keep_run with no added register. The bench drives the reference and the configuration away from the sampling edge and reads the outputs on the falling edge. Each check of unlock is placed before the earliest or after the latest cycle the requirement allows, with a margin that covers the synchronizer delay plus one reference period. Lock deadlines come from bench functions of LOCK_CYC and the reference period, so every pass or fail decision is made outside that uncertainty window.

// File: rtl/refwd_pkg.sv
package refwd_pkg;
    typedef enum logic {
        ST_UNLOCKED = 1'b0,
        ST_LOCKED   = 1'b1
    } lock_st_e;
endpackage

// File: rtl/refwd_edge_det.sv
module refwd_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic rise_o
);
    localparam int PW = STAGES + 1;

    logic [PW-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[PW-2:0], ref_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign rise_o = pipe_q[PW-2] & ~pipe_q[PW-1];
endmodule

// File: rtl/refwd_period_meter.sv
module refwd_period_meter #(
    parameter int TO_EXP = 23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise_i,
    input  logic          hold_i,
    output logic [TO_EXP:0] gap_o,
    output logic [TO_EXP:0] period_o,
    output logic          have_o,
    output logic          timeout_o
);
    typedef struct packed {
        logic [TO_EXP-1:0] cnt;
        logic [TO_EXP:0]   period;
        logic              seen;
        logic              have;
    } meter_t;

    meter_t m_d, m_q;

    assign gap_o     = {1'b0, m_q.cnt} + 1'b1;
    assign timeout_o = (&m_q.cnt) & ~rise_i;
    assign period_o  = m_q.period;
    assign have_o    = m_q.have;

    always_comb begin
        m_d = m_q;
        if (rise_i) begin
            m_d.cnt = '0;
            if (!m_q.seen) begin
                m_d.seen = 1'b1;
            end else if (!m_q.have) begin
                m_d.have   = 1'b1;
                m_d.period = gap_o;
            end else if (!hold_i) begin
                m_d.period = gap_o;
            end
        end else if (timeout_o) begin
            m_d.seen = 1'b0;
            m_d.have = 1'b0;
        end else begin
            m_d.cnt = m_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end
endmodule

// File: rtl/refclk_watchdog.sv
module refclk_watchdog #(
    parameter int TO_EXP      = 23,
    parameter int LOCK_CYC    = 4096,
    parameter int SKIP_MIN    = 256,
    parameter int TOL         = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_clk,
    input  logic cfg_keep_run,
    input  logic cfg_skip_en,
    output logic unlock,
    output logic out_en,
    output logic out_invalid
);
    import refwd_pkg::*;

    localparam int GW = TO_EXP + 1;
    localparam int LW = $clog2(LOCK_CYC + 1);
    localparam logic [GW:0]   TOL_W  = (GW+1)'(TOL);
    localparam logic [GW-1:0] SKIP_W = GW'(SKIP_MIN);
    localparam logic [LW-1:0] LK_END = LW'(LOCK_CYC - 1);

    logic          rise_w, hold_w, have_w, timeout_w;
    logic [GW-1:0] gap_w, period_w;
    logic          slow_w, fast_w, skip_ok, change_w;

    refwd_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_i  (ref_clk),
        .rise_o (rise_w)
    );

    refwd_period_meter #(.TO_EXP(TO_EXP)) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (rise_w),
        .hold_i    (hold_w),
        .gap_o     (gap_w),
        .period_o  (period_w),
        .have_o    (have_w),
        .timeout_o (timeout_w)
    );

    typedef struct packed {
        lock_st_e        st;
        logic [LW-1:0]   lk;
    } ctl_t;

    ctl_t c_d, c_q;

    // Period comparison one bit wider than the gap so the tolerance add cannot wrap.
    assign slow_w   = have_w && ({1'b0, gap_w} > ({1'b0, period_w} + TOL_W));
    assign fast_w   = have_w && ({1'b0, period_w} > ({1'b0, gap_w} + TOL_W));
    assign skip_ok  = rise_w && slow_w && cfg_skip_en && (gap_w >= SKIP_W)
                      && (c_q.st == ST_LOCKED);
    assign hold_w   = skip_ok;
    assign change_w = rise_w && (slow_w || fast_w) && !skip_ok;

    always_comb begin
        c_d = c_q;
        unique case (c_q.st)
            ST_LOCKED: begin
                if (timeout_w || change_w) begin
                    c_d.st = ST_UNLOCKED;
                    c_d.lk = '0;
                end
            end
            default: begin
                if (timeout_w || change_w || !have_w || slow_w) begin
                    c_d.lk = '0;
                end else if (c_q.lk == LK_END) begin
                    c_d.st = ST_LOCKED;
                    c_d.lk = '0;
                end else begin
                    c_d.lk = c_q.lk + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.st <= ST_UNLOCKED;
            c_q.lk <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign unlock      = (c_q.st == ST_UNLOCKED);
    assign out_en      = !unlock || cfg_keep_run;
    assign out_invalid = unlock && cfg_keep_run;
endmodule

// File: rtl/refclk_watchdog_chk.sv
module refclk_watchdog_chk #(
    parameter int TO_EXP   = 23,
    parameter int LOCK_CYC = 4096,
    parameter int SKIP_MIN = 256,
    parameter int TOL      = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_skip_en,
    input logic          unlock,
    input logic          out_invalid,
    input logic          rise,
    input logic          have,
    input logic          timeout,
    input logic [TO_EXP:0] gap,
    input logic [TO_EXP:0] period
);
    localparam int LW = $clog2(LOCK_CYC + 1);
    localparam logic [LW-1:0] RUN_MAX = LW'(LOCK_CYC);

    logic [LW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                          run_q <= '0;
        else if (!unlock)                    run_q <= '0;
        else if (run_q != RUN_MAX)           run_q <= run_q + 1'b1;
    end

    AST_CLEAN_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlock && !rise && !timeout) |=> !unlock); // R1
    AST_TIMEOUT_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> unlock); // R1
    AST_FAST_EDGE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlock && rise && have && (int'(period) > int'(gap) + TOL)) |=> unlock); // R2
    AST_INVALID_ONLY_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> unlock); // R3
    AST_MIN_LOCK_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock && (run_q < LW'(LOCK_CYC - 1))) |=> unlock); // R4
    AST_SKIP_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlock && cfg_skip_en && rise && have && (int'(gap) >= SKIP_MIN)
         && (int'(gap) > int'(period) + TOL)) |=> !unlock); // R5
endmodule

bind refclk_watchdog refclk_watchdog_chk #(
    .TO_EXP   (TO_EXP),
    .LOCK_CYC (LOCK_CYC),
    .SKIP_MIN (SKIP_MIN),
    .TOL      (TOL)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_skip_en (cfg_skip_en),
    .unlock      (unlock),
    .out_invalid (out_invalid),
    .rise        (rise_w),
    .have        (have_w),
    .timeout     (timeout_w),
    .gap         (gap_w),
    .period      (period_w)
);

// File: tb/refclk_watchdog_tb.sv
module refclk_watchdog_tb;
    localparam int TO_EXP   = 10;
    localparam int TIMEOUT  = 1 << TO_EXP;
    localparam int LOCK_CYC = 200;
    localparam int SKIP_MIN = 64;
    localparam int TOL      = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_clk = 1'b0;
    logic cfg_keep_run = 1'b1;
    logic cfg_skip_en = 1'b0;
    logic unlock, out_en, out_invalid;

    always #2 clk = ~clk;

    refclk_watchdog #(
        .TO_EXP(TO_EXP), .LOCK_CYC(LOCK_CYC), .SKIP_MIN(SKIP_MIN), .TOL(TOL)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk),
        .cfg_keep_run(cfg_keep_run), .cfg_skip_en(cfg_skip_en),
        .unlock(unlock), .out_en(out_en), .out_invalid(out_invalid)
    );

    int  n_chk = 0, n_fail = 0;
    int  cyc = 0;
    int  half = 4, phase = 0;
    bit  ref_on = 1'b1, glitch_req = 1'b0, jit_en = 1'b0, xtra = 1'b0;
    bit  done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Reference generator: period 2*half (+1 on alternate periods when jitter is on).
    always @(negedge clk) begin
        if (!ref_on) begin
            ref_clk <= 1'b0;
            phase   <= 0;
            xtra    <= 1'b0;
        end else begin
            ref_clk <= (phase < half) || (glitch_req && phase == half + 1);
            if (phase >= 2*half + int'(xtra) - 1) begin
                phase <= 0;
                xtra  <= jit_en ? !xtra : 1'b0;
            end else begin
                phase <= phase + 1;
            end
        end
    end

    function automatic logic exp_en(logic unl, logic keep);
        return !unl || keep;
    endfunction
    function automatic logic exp_inv(logic unl, logic keep);
        return unl && keep;
    endfunction
    function automatic int lock_by(int per);
        return LOCK_CYC + 2*per + 12;
    endfunction

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic gate(string req, logic exp_unl);
        @(negedge clk);
        chk({req, " unlock"}, unlock, exp_unl);
        chk({req, " out_en"}, out_en, exp_en(exp_unl, cfg_keep_run));
        chk({req, " out_invalid"}, out_invalid, exp_inv(exp_unl, cfg_keep_run));
    endtask

    task automatic wait_to(int t);
        while (cyc < t) @(posedge clk);
    endtask

    task automatic set_ref(bit on);
        @(posedge clk);
        ref_on <= on;
    endtask

    task automatic glitch();
        @(posedge clk);
        glitch_req <= 1'b1;
        repeat (2*half) @(posedge clk);
        glitch_req <= 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        int t0;
        int t;
        int g;
        bit sk;
        void'($urandom(32'h1F2E3D4C));

        // R9: reset state, both gate settings
        repeat (4) @(posedge clk);
        gate("R9 reset keep=1", 1'b1);
        @(posedge clk); cfg_keep_run <= 1'b0;
        gate("R9 reset keep=0", 1'b1);

        @(posedge clk); rst_n <= 1'b1;
        t0 = cyc;
        // R10: gate follows cfg during acquisition, lock count not disturbed
        for (int i = 0; i < 6; i++) begin
            repeat (10 + ($urandom % 15)) @(posedge clk);
            cfg_keep_run <= !cfg_keep_run;
            cfg_skip_en  <= $urandom % 2;
            gate("R10 cfg change while acquiring", 1'b1);
        end
        wait_to(t0 + LOCK_CYC - 5);
        gate("R9 still unlocked before lock time", 1'b1);
        wait_to(t0 + lock_by(2*half));
        gate("R10 lock reached despite cfg changes", 1'b0);

        // R1: clean stop for both skip values, then R3 gating and R4 reacquire
        for (int s = 0; s < 2; s++) begin
            @(posedge clk); cfg_skip_en <= s[0];
            set_ref(1'b0);
            t = cyc;
            wait_to(t + TIMEOUT - 2*half - 6);
            gate("R1 held before timeout", 1'b0);
            wait_to(t + TIMEOUT + 8);
            gate("R1 unlock after timeout", 1'b1);
            @(posedge clk); cfg_keep_run <= 1'b0;
            gate("R3 held low while unlocked", 1'b1);
            @(posedge clk); cfg_keep_run <= 1'b1;
            gate("R3 run invalid while unlocked", 1'b1);
            set_ref(1'b1);
            t = cyc;
            wait_to(t + LOCK_CYC - 5);
            gate("R4 unlocked during lock time", 1'b1);
            wait_to(t + lock_by(2*half));
            gate("R4 lock after lock time", 1'b0);
        end

        // R2: early edge unlocks at once, both skip values
        for (int s = 0; s < 2; s++) begin
            @(posedge clk); cfg_skip_en <= s[0];
            gate("R2 locked before glitch", 1'b0);
            glitch();
            repeat (6) @(posedge clk);
            gate("R2 unlock after glitch", 1'b1);
            t = cyc;
            wait_to(t + lock_by(2*half));
            gate("R4 relock after glitch", 1'b0);
        end

        // R7: slower period beyond tolerance unlocks even with skip enabled
        @(posedge clk); cfg_skip_en <= 1'b1; half <= 6;
        repeat (40) @(posedge clk);
        gate("R7 period change unlocks", 1'b1);
        t = cyc;
        wait_to(t + lock_by(2*half));
        gate("R7 relock at new period", 1'b0);
        @(posedge clk); jit_en <= 1'b1;
        repeat (150) @(posedge clk);
        gate("R7 one-cycle jitter keeps lock", 1'b0);
        @(posedge clk); jit_en <= 1'b0;
        repeat (30) @(posedge clk);
        gate("R7 locked after jitter off", 1'b0);

        // R5/R6: interruption between SKIP_MIN and timeout, directed then random
        for (int r = 0; r < 8; r++) begin
            if (r < 2) begin
                sk = r[0];
                g  = 300;
            end else begin
                sk = $urandom % 2;
                g  = SKIP_MIN + 10 + ($urandom % (TIMEOUT - SKIP_MIN - 200));
            end
            @(posedge clk); cfg_skip_en <= sk; cfg_keep_run <= $urandom % 2;
            set_ref(1'b0);
            repeat (g) @(posedge clk);
            set_ref(1'b1);
            repeat (10) @(posedge clk);
            if (sk) begin
                gate("R5 skip keeps lock", 1'b0);
                repeat (6*half) @(posedge clk);
                gate("R5 old period kept after skip", 1'b0);
            end else begin
                gate("R6 no skip unlocks on return", 1'b1);
                t = cyc;
                wait_to(t + lock_by(2*half));
                gate("R6 relock after return", 1'b0);
            end
        end

        // R8: quiet spell during acquisition restarts the lock count
        glitch();
        t0 = cyc;
        wait_to(t0 + 100);
        set_ref(1'b0);
        repeat (40) @(posedge clk);
        set_ref(1'b1);
        t = cyc;
        wait_to(t0 + lock_by(2*half));
        gate("R8 lock count restarted", 1'b1);
        wait_to(t + LOCK_CYC + 6*half + 20);
        gate("R8 lock after restarted count", 1'b0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule